// File: doc/BRIEF.md
# Input Scaler with Sampling FIFO

The block counts rising edges on a set of asynchronous input lines. Every line is first synchronised to the clock. It is then XORed with a per-line invert bit and gated with a per-line enable bit. Each rising edge of the conditioned level advances a free-running counter of that line, and the counter wraps when it overflows. Software can read any counter at any time over a simple register bus, read the present level of every line, and clear all counters with one control write.

Setting the start bit of the control word begins a capture. The capture empties the sampling FIFO, then takes snapshots of one counter at a programmable interval. A five-bit select field in the same control word picks that counter. The capture stops by itself after a fixed number of samples. Each read of the FIFO window removes one entry. The returned word carries an empty flag above the data bits, and that flag tells software when no valid sample remains. A status register shows the busy flag, the FIFO state and the number of samples taken so far.

Top module: `input_scaler`

## Requirements
- R1: After reset all counters read 0, the enable, invert and interval registers read 0, the status word reads 0x0000_0004 (empty bit 2 set, busy bit 0 and full bit 1 clear, sample count 0), and a FIFO read returns 0x0002_0000.
- R2: A counter advances by one for each rising edge of its synchronised input gated by the enable mask at 0xcf80 (bit n = line n). A line with enable 0 does not count.
- R3: The invert mask at 0xcf81 (bit n = line n) inverts line n before edge detection. Turning on inversion while the line is low is therefore one rising edge, and each later high-to-low transition of the pin counts.
- R4: Counters are CNT_W bits wide and wrap to 0 after their maximum value.
- R5: Writing 0xcf8f with bit 1 set clears every counter. Bits 20:16 of that write set the capture source line. Bits 0 and 1 always read back 0.
- R6: Writing 0xcf8f with bit 0 set empties the FIFO, sets busy, and restarts the sample count at 0, even when a capture is already running.
- R7: While busy, the counter of the selected line is pushed every N cycles, where N is the value at 0xcf82 and 0 acts as 1. The first push lands N cycles after the start write. Busy clears after exactly SAMPLES pushes.
- R8: Status at 0xcf84 holds busy in bit 0, FIFO full in bit 1, FIFO empty in bit 2, and the sample count in bits 31:16.
- R9: A read in 0xcfa0..0xcfbf returns the oldest entry zero-extended with bit 17 = 0 and pops it. When the FIFO is empty it returns 0x0002_0000 and pops nothing. The stored data are the low 17 bits of the counter.
- R10: A read at 0xcfc0 + n returns counter n. A value of n at or above NUM_IN reads 0.
- R11: The value of a read appears on bus_rdata with rd_ack high in the cycle after bus_rd is sampled.
- R12: A read at 0xcf8e returns the synchronised level of every input line, bit n = line n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sig_in | input | NUM_IN | Asynchronous lines to be counted |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_rd | input | 1 | Register read strobe, one cycle |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with rd_ack |
| rd_ack | output | 1 | High one cycle after an accepted read |

## Verification
The bench runs a capture at interval 4 and reads the status word mid-capture. If the design pushed on the start cycle or miscounted the interval, the sample count it reports would be off by one. A second capture restarts the first one before its data has been drained. A design that did not empty the FIFO on start would return stale samples ahead of the new ones, or would never show the empty word. The bench also turns on inversion on an idle line, which must count as one edge, and drives a counter past its width so that a counter without wrap would read a wrong value. Finally it reads a counter index above the number of lines and reads the control word, which must show neither a phantom count nor a sticky start or clear bit.

// File: rtl/iscal_pkg.sv
package iscal_pkg;

   localparam logic [15:0] ADR_EN_MASK  = 16'hcf80;
   localparam logic [15:0] ADR_INV_MASK = 16'hcf81;
   localparam logic [15:0] ADR_INTERVAL = 16'hcf82;
   localparam logic [15:0] ADR_STATUS   = 16'hcf84;
   localparam logic [15:0] ADR_LEVELS   = 16'hcf8e;
   localparam logic [15:0] ADR_CONTROL  = 16'hcf8f;

   // 32-word pages, selected by address bits 15:5
   localparam logic [10:0] PAGE_FIFO    = 11'h67d;
   localparam logic [10:0] PAGE_COUNT   = 11'h67e;

   localparam int SEL_W   = 5;
   localparam int SEL_LSB = 16;

   typedef struct packed {
      logic             start;
      logic             clear;
      logic [SEL_W-1:0] sel;
      logic             sel_we;
   } ctl_cmd_t;

endpackage

// File: rtl/iscal_chan.sv
module iscal_chan #(
   parameter int CNT_W       = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin,
   input  logic             en,
   input  logic             inv,
   input  logic             clr,
   output logic             level,
   output logic [CNT_W-1:0] count
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   cond;
   logic                   cond_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
   end

   assign level = sync_q[SYNC_STAGES-1];
   assign cond  = (level ^ inv) & en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cond_q <= 1'b0;
         count  <= '0;
      end else begin
         cond_q <= cond;
         if (clr)                 count <= '0;
         else if (cond && !cond_q) count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/iscal_fifo.sv
module iscal_fifo #(
   parameter int DW    = 17,
   parameter int DEPTH = 1024,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic          empty,
   output logic          full,
   output logic [AW:0]   level
);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          do_push, do_pop;

   assign empty   = (level == '0);
   assign full    = (level == (AW+1)'(DEPTH));
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign rdata   = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

endmodule

// File: rtl/iscal_capture.sv
module iscal_capture #(
   parameter int SAMPLES = 1024,
   parameter int RATE_W  = 16,
   localparam int SC_W   = $clog2(SAMPLES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [RATE_W-1:0] rate,
   output logic              busy,
   output logic              push,
   output logic [SC_W-1:0]   nsamp
);

   logic [RATE_W-1:0] tick;
   logic [RATE_W-1:0] limit;
   logic              hit;

   assign limit = (rate == '0) ? '0 : rate - 1'b1;
   assign hit   = (tick >= limit);
   assign push  = busy && hit && !start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         tick  <= '0;
         nsamp <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         tick  <= '0;
         nsamp <= '0;
      end else if (busy) begin
         if (hit) begin
            tick  <= '0;
            nsamp <= nsamp + 1'b1;
            if (nsamp == SC_W'(SAMPLES - 1)) busy <= 1'b0;
         end else begin
            tick <= tick + 1'b1;
         end
      end
   end

endmodule

// File: rtl/input_scaler.sv
module input_scaler
   import iscal_pkg::*;
#(
   parameter int NUM_IN      = 32,
   parameter int CNT_W       = 24,
   parameter int DATA_W      = 17,
   parameter int FIFO_DEPTH  = 1024,
   parameter int SAMPLES     = 1024,
   parameter int RATE_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] sig_in,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [15:0]       bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              rd_ack
);

   localparam int FIFO_AW = $clog2(FIFO_DEPTH);
   localparam int SC_W    = $clog2(SAMPLES + 1);
   localparam int FLAT_W  = NUM_IN * CNT_W;

   generate
      if (NUM_IN < 1 || NUM_IN > 32)
         $error("NUM_IN must lie in 1..32");
      if (CNT_W < 1 || CNT_W > 32)
         $error("CNT_W must lie in 1..32");
      if (DATA_W < 1 || DATA_W > 31)
         $error("DATA_W must leave room for the empty flag");
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0)
         $error("FIFO_DEPTH must be a power of two");
      if (SAMPLES < 1 || SAMPLES > 65535)
         $error("SAMPLES must fit the 16-bit status field");
      if (RATE_W < 1 || RATE_W > 32)
         $error("RATE_W must lie in 1..32");
      if (SYNC_STAGES < 2)
         $error("SYNC_STAGES must be at least 2");
   endgenerate

   // ---------------- configuration registers ----------------
   logic [NUM_IN-1:0] en_mask, inv_mask;
   logic [RATE_W-1:0] interval;
   logic [SEL_W-1:0]  src_sel;
   ctl_cmd_t          cmd;
   logic              unused_wdata;

   assign unused_wdata = ^bus_wdata;

   always_comb begin
      cmd        = '0;
      cmd.sel_we = bus_wr && (bus_addr == ADR_CONTROL);
      cmd.start  = cmd.sel_we && bus_wdata[0];
      cmd.clear  = cmd.sel_we && bus_wdata[1];
      cmd.sel    = bus_wdata[SEL_LSB +: SEL_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_mask  <= '0;
         inv_mask <= '0;
         interval <= '0;
         src_sel  <= '0;
      end else if (bus_wr) begin
         if (bus_addr == ADR_EN_MASK)  en_mask  <= bus_wdata[NUM_IN-1:0];
         if (bus_addr == ADR_INV_MASK) inv_mask <= bus_wdata[NUM_IN-1:0];
         if (bus_addr == ADR_INTERVAL) interval <= bus_wdata[RATE_W-1:0];
         if (cmd.sel_we)               src_sel  <= cmd.sel;
      end
   end

   // ---------------- per-line counters ----------------
   logic [NUM_IN-1:0] levels;
   logic [CNT_W-1:0]  cnt [NUM_IN];
   logic [FLAT_W-1:0] cnt_flat;

   generate
      for (genvar g = 0; g < NUM_IN; g++) begin : g_chan
         iscal_chan #(
            .CNT_W      (CNT_W),
            .SYNC_STAGES(SYNC_STAGES)
         ) u_chan (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (sig_in[g]),
            .en   (en_mask[g]),
            .inv  (inv_mask[g]),
            .clr  (cmd.clear),
            .level(levels[g]),
            .count(cnt[g])
         );
         assign cnt_flat[g*CNT_W +: CNT_W] = cnt[g];
      end
   endgenerate

   // ---------------- capture path ----------------
   logic [CNT_W-1:0]  src_cnt;
   logic              busy, push;
   logic [SC_W-1:0]   nsamp;
   logic [DATA_W-1:0] fifo_head;
   logic              fifo_empty, fifo_full, fifo_pop;
   logic [FIFO_AW:0]  fifo_level;

   always_comb begin
      src_cnt = '0;
      for (int i = 0; i < NUM_IN; i++)
         if (src_sel == SEL_W'(i)) src_cnt = cnt[i];
   end

   iscal_capture #(
      .SAMPLES(SAMPLES),
      .RATE_W (RATE_W)
   ) u_capture (
      .clk  (clk),
      .rst_n(rst_n),
      .start(cmd.start),
      .rate (interval),
      .busy (busy),
      .push (push),
      .nsamp(nsamp)
   );

   assign fifo_pop = bus_rd && (bus_addr[15:5] == PAGE_FIFO);

   iscal_fifo #(
      .DW   (DATA_W),
      .DEPTH(FIFO_DEPTH)
   ) u_fifo (
      .clk  (clk),
      .rst_n(rst_n),
      .flush(cmd.start),
      .push (push),
      .wdata(DATA_W'(src_cnt)),
      .pop  (fifo_pop),
      .rdata(fifo_head),
      .empty(fifo_empty),
      .full (fifo_full),
      .level(fifo_level)
   );

   // ---------------- read-back ----------------
   logic [CNT_W-1:0]  idx_cnt;
   logic [31:0]       rd_mux;

   always_comb begin
      idx_cnt = '0;
      for (int i = 0; i < NUM_IN; i++)
         if (bus_addr[4:0] == 5'(i)) idx_cnt = cnt[i];
   end

   always_comb begin
      rd_mux = '0;
      if (bus_addr[15:5] == PAGE_FIFO)
         rd_mux = fifo_empty ? (32'd1 << DATA_W) : 32'(fifo_head);
      else if (bus_addr[15:5] == PAGE_COUNT)
         rd_mux = 32'(idx_cnt);
      else begin
         case (bus_addr)
            ADR_EN_MASK:  rd_mux = 32'(en_mask);
            ADR_INV_MASK: rd_mux = 32'(inv_mask);
            ADR_INTERVAL: rd_mux = 32'(interval);
            ADR_STATUS:   rd_mux = {16'(nsamp), 13'd0, fifo_empty, fifo_full, busy};
            ADR_LEVELS:   rd_mux = 32'(levels);
            ADR_CONTROL:  rd_mux = 32'(src_sel) << SEL_LSB;
            default:      rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         rd_ack    <= 1'b0;
      end else begin
         rd_ack <= bus_rd;
         if (bus_rd) bus_rdata <= rd_mux;
      end
   end

endmodule

// File: rtl/input_scaler_chk.sv
module input_scaler_chk #(
   parameter int DEPTH   = 1024,
   parameter int SAMPLES = 1024,
   parameter int LVL_W   = 11,
   parameter int SC_W    = 11,
   parameter int FLAT_W  = 768
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_rd,
   input logic              rd_ack,
   input logic              start,
   input logic              clear,
   input logic              busy,
   input logic [SC_W-1:0]   nsamp,
   input logic [LVL_W-1:0]  fifo_level,
   input logic              fifo_empty,
   input logic              fifo_pop,
   input logic [FLAT_W-1:0] cnt_flat
);

   // R8: occupancy never exceeds the storage
   p_level_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_level <= LVL_W'(DEPTH));

   // R7: a capture ends only after the full sample count
   p_done_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> nsamp == SC_W'(SAMPLES));

   // R6: start empties the FIFO and raises busy
   p_start_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy && fifo_level == '0));

   // R5: clear command zeroes every counter
   p_clear_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> cnt_flat == '0);

   // R11: every read is acknowledged in the next cycle, and only then
   p_ack_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> rd_ack);
   p_ack_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> !rd_ack);

   // R9: a FIFO read while idle removes exactly one entry
   p_pop_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_pop && !fifo_empty && !busy && !start)
      |=> fifo_level == $past(fifo_level) - 1'b1);

endmodule

bind input_scaler input_scaler_chk #(
   .DEPTH  (FIFO_DEPTH),
   .SAMPLES(SAMPLES),
   .LVL_W  (FIFO_AW + 1),
   .SC_W   (SC_W),
   .FLAT_W (FLAT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_rd    (bus_rd),
   .rd_ack    (rd_ack),
   .start     (cmd.start),
   .clear     (cmd.clear),
   .busy      (busy),
   .nsamp     (nsamp),
   .fifo_level(fifo_level),
   .fifo_empty(fifo_empty),
   .fifo_pop  (fifo_pop),
   .cnt_flat  (cnt_flat)
);

// File: tb/input_scaler_test.sv
`timescale 1ns/1ps
module input_scaler_test;

   localparam int NI   = 4;
   localparam int CW   = 8;
   localparam int DEP  = 8;
   localparam int SMP  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NI-1:0] sig_in = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [15:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          rd_ack;

   int errors = 0;
   int checks = 0;
   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #10 clk = ~clk;

   input_scaler #(
      .NUM_IN(NI), .CNT_W(CW), .DATA_W(17), .FIFO_DEPTH(DEP),
      .SAMPLES(SMP), .RATE_W(16), .SYNC_STAGES(2)
   ) uut (
      .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .rd_ack(rd_ack)
   );

   // all tasks are entered at a falling edge and leave at one
   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_expect(input logic [15:0] a, input logic [31:0] e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic pulse(input int ch, input int n);
      for (int k = 0; k < n; k++) begin
         sig_in[ch] = 1'b1;
         repeat (2) @(negedge clk);
         sig_in[ch] = 1'b0;
         repeat (2) @(negedge clk);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: compare each acknowledged read against the scoreboard
   always @(negedge clk) begin
      if (rst_n && rd_ack) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL unexpected read ack: actual %h expected none", bus_rdata);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (bus_rdata !== e) begin
               errors++;
               $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      rd_expect(16'hcfc0, 32'h0, "R1 counter 0 after reset");
      rd_expect(16'hcf80, 32'h0, "R1 enable mask after reset");
      rd_expect(16'hcf84, 32'h0000_0004, "R1 status after reset");
      rd_expect(16'hcfa0, 32'h0002_0000, "R1/R9 empty FIFO word after reset");

      // R2 counting with enable mask (line 2 disabled)
      wr(16'hcf80, 32'hB);
      wr(16'hcf81, 32'h0);
      pulse(0, 5);
      pulse(2, 3);
      idle(4);
      rd_expect(16'hcfc0, 32'd5, "R2 enabled line 0 counts edges");
      rd_expect(16'hcfc2, 32'd0, "R2 disabled line 2 stays at 0");

      // R12 levels
      sig_in[3] = 1'b1;
      idle(4);
      rd_expect(16'hcf8e, 32'h8, "R12 synchronised levels");
      rd_expect(16'hcfc3, 32'd1, "R2 line 3 one edge");
      sig_in[3] = 1'b0;
      idle(4);

      // R3 inversion: enabling it on a low line is one edge, then each pulse one more
      wr(16'hcf81, 32'h2);
      idle(4);
      pulse(1, 3);
      idle(4);
      rd_expect(16'hcfc1, 32'd4, "R3 inverted line 1 count");

      // R4 wrap: 5 + 253 = 258 -> 2 in 8 bits
      pulse(0, 253);
      idle(4);
      rd_expect(16'hcfc0, 32'd2, "R4 counter wraps");

      // R10 index above NUM_IN
      rd_expect(16'hcfc5, 32'd0, "R10 out-of-range counter index");

      // R7 capture at interval 4 from line 1 (value 4)
      wr(16'hcf82, 32'd4);
      wr(16'hcf8f, 32'h0001_0001);
      idle(9);
      rd_expect(16'hcf84, 32'h0002_0001, "R7/R8 mid-capture status");
      idle(40);
      rd_expect(16'hcf84, 32'h0008_0002, "R7/R8 status after capture, full");
      rd_expect(16'hcf8f, 32'h0001_0000, "R5 control readback self-clears");
      rd_expect(16'hcfa0, 32'd4, "R9 first sample of line 1");
      rd_expect(16'hcfb7, 32'd4, "R9 second sample via window alias");

      // R6 restart with interval 0 from line 0 (value 2)
      wr(16'hcf82, 32'd0);
      wr(16'hcf8f, 32'h0000_0001);
      idle(2);
      rd_expect(16'hcf84, 32'h0002_0001, "R6/R7 interval 0 samples every cycle");
      idle(20);
      for (int k = 0; k < SMP; k++)
         rd_expect(16'hcfa0, 32'd2, "R6 FIFO holds only new samples");
      rd_expect(16'hcfa0, 32'h0002_0000, "R9 empty flag after draining");
      rd_expect(16'hcf84, 32'h0008_0004, "R8 status after draining");

      // R5 clear counters
      wr(16'hcf8f, 32'h0000_0002);
      idle(2);
      rd_expect(16'hcfc0, 32'd0, "R5 counter 0 cleared");
      rd_expect(16'hcfc1, 32'd0, "R5 counter 1 cleared");
      rd_expect(16'hcfc3, 32'd0, "R5 counter 3 cleared");
      rd_expect(16'hcf84, 32'h0008_0004, "R5 clear starts no capture");

      idle(4);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R11 missing acks: actual %0d pending expected 0", exp_q.size());
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule